// File: doc/BRIEF.md
# Instruction Cache Tag Maintenance Port

This block is a bus-reachable window onto the tag store of an instruction cache. A bus master issues single accesses. The block recognises its own address window and takes an entry index and an association flag from the address. Reads return the stored tag and valid bit. Plain writes overwrite both. Associative writes let software invalidate a line by naming its tag: the stored tag is compared with the supplied one, and only on an agreement with a live entry is the valid bit rewritten. The tag itself is never touched by an associative write.

When the translation enable input is high, an associative write first sends its tag field to an external translator over a valid/ready request. The block then waits for a one-cycle response carrying a physical tag together with hit and multiple-hit flags. While it waits, the port is not ready for a new access. A miss or a tag disagreement ends the access silently. A multiple hit ends it with an exception-request pulse and leaves the entry untouched. The tag store is a local register array. Every access that the block accepts ends with a one-cycle done strobe.

Top module: `icache_tag_port`

## Requirements
- R1: An access whose address bits 31:24 differ from 0xF0 is ignored: no done strobe follows, acc_ready stays high and no entry changes.
- R2: A read (acc_we=0) returns the entry chosen by address bits 12:5 as tag in data bits 31:10 and valid in bit 0. The association flag (address bit 3) does not alter the result, and a read changes no entry.
- R3: A write with address bit 3 clear stores data bits 31:10 as the tag and data bit 0 as the valid bit of the chosen entry, whatever they held before.
- R4: With translation disabled, a write with address bit 3 set, whose data tag equals the stored tag of a valid entry, writes data bit 0 into the valid bit and leaves the tag unchanged.
- R5: An associative write whose tag disagrees with the stored tag, or whose entry is invalid, changes nothing and raises no exception.
- R6: With translation enabled, an associative write sends data bits 31:10 on xl_req_vtag, holds it stable until it is accepted, keeps acc_ready low until the response, and compares the returned physical tag with the stored tag.
- R7: A translator response with hit=0 ends the associative write as a no-op without acc_exc.
- R8: A translator response with multi=1 pulses acc_exc in the done cycle and leaves the entry unchanged.
- R9: Reset clears every valid bit and zeroes every tag, so a read after reset returns 0.
- R10: acc_done is high for one cycle, in the cycle after acceptance for a read, a plain write or an untranslated associative write, and in the cycle after the translator response otherwise. Read data is valid together with acc_done.
- R11: Data bits 9:1 are ignored on write and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xlat_en | input | 1 | Route associative-write tags through the translator |
| acc_start | input | 1 | Access request, taken when acc_ready is high |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Access address (window, index, association flag) |
| acc_wdata | input | 32 | Write data word |
| acc_ready | output | 1 | Port idle and able to take an access |
| acc_done | output | 1 | One-cycle end-of-access strobe |
| acc_rdata | output | 32 | Read data, valid with acc_done |
| acc_exc | output | 1 | Exception-request pulse on a translator multiple hit |
| xl_req_valid | output | 1 | Translation request valid |
| xl_req_vtag | output | 22 | Virtual tag to translate |
| xl_req_ready | input | 1 | Translator takes the request |
| xl_rsp_valid | input | 1 | Translator response valid (one cycle) |
| xl_rsp_ptag | input | 22 | Translated physical tag |
| xl_rsp_hit | input | 1 | Translation hit |
| xl_rsp_multi | input | 1 | Multiple translation hits |

## Verification
The bench builds the block with its default parameters: window 0xF0, 8 index bits at bit 5, association flag at bit 3 and a 22-bit tag. Entry 0 and entry 255 are therefore both reachable, and the full tag width can be driven all-ones to expose truncation. A translator model with a response delay of a few cycles drives the hit, miss, tag-mismatch and multiple-hit cases, so the stall and the single exception pulse can be seen at the ports.

// File: rtl/icache_tag_port.sv
module icache_tag_port #(
  parameter logic [7:0] WIN_TAG   = 8'hF0,
  parameter int         IDX_W     = 8,
  parameter int         IDX_LSB   = 5,
  parameter int         ASSOC_BIT = 3,
  parameter int         TAG_W     = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xlat_en,
  input  logic             acc_start,
  input  logic             acc_we,
  input  logic [31:0]      acc_addr,
  input  logic [31:0]      acc_wdata,
  output logic             acc_ready,
  output logic             acc_done,
  output logic [31:0]      acc_rdata,
  output logic             acc_exc,
  output logic             xl_req_valid,
  output logic [TAG_W-1:0] xl_req_vtag,
  input  logic             xl_req_ready,
  input  logic             xl_rsp_valid,
  input  logic [TAG_W-1:0] xl_rsp_ptag,
  input  logic             xl_rsp_hit,
  input  logic             xl_rsp_multi
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int PAD_W   = 32 - TAG_W - 1;

  typedef enum logic [1:0] {S_IDLE, S_XREQ, S_XWAIT} st_t;
  st_t st_q;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;
  logic [IDX_W-1:0] op_idx;
  logic [TAG_W-1:0] op_vtag;
  logic             op_v;

  wire             in_win = acc_addr[31:24] == WIN_TAG;
  wire [IDX_W-1:0] idx    = acc_addr[IDX_LSB +: IDX_W];
  wire             assoc  = acc_addr[ASSOC_BIT];
  wire [TAG_W-1:0] dtag   = acc_wdata[31 -: TAG_W];
  wire             accept = acc_start && st_q == S_IDLE && in_win;
  wire             hit_ok = xl_rsp_hit && xl_rsp_ptag == tag_q[op_idx] && vld_q[op_idx];

  assign acc_ready    = st_q == S_IDLE;
  assign xl_req_valid = st_q == S_XREQ;
  assign xl_req_vtag  = op_vtag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      acc_done  <= 1'b0;
      acc_exc   <= 1'b0;
      acc_rdata <= '0;
      vld_q     <= '0;
      op_idx    <= '0;
      op_vtag   <= '0;
      op_v      <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '0;
    end else begin
      acc_done <= 1'b0;
      acc_exc  <= 1'b0;
      case (st_q)
        S_IDLE: if (accept) begin
          if (!acc_we) begin
            acc_rdata <= {tag_q[idx], {PAD_W{1'b0}}, vld_q[idx]};
            acc_done  <= 1'b1;
          end else if (!assoc) begin
            tag_q[idx] <= dtag;
            vld_q[idx] <= acc_wdata[0];
            acc_done   <= 1'b1;
          end else if (!xlat_en) begin
            if (tag_q[idx] == dtag && vld_q[idx]) vld_q[idx] <= acc_wdata[0];
            acc_done <= 1'b1;
          end else begin
            op_idx  <= idx;
            op_vtag <= dtag;
            op_v    <= acc_wdata[0];
            st_q    <= S_XREQ;
          end
        end
        S_XREQ: if (xl_req_ready) st_q <= S_XWAIT;
        S_XWAIT: if (xl_rsp_valid) begin
          st_q     <= S_IDLE;
          acc_done <= 1'b1;
          if (xl_rsp_multi) acc_exc <= 1'b1;
          else if (hit_ok) vld_q[op_idx] <= op_v;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_outside_window_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && acc_ready && !in_win) |=> !acc_done);

  p_read_keeps_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !acc_we) |=> $stable(vld_q));

  p_xlat_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req_valid && !xl_req_ready) |=> (xl_req_valid && $stable(xl_req_vtag)));

  p_multi_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_XWAIT && xl_rsp_valid && xl_rsp_multi) |=> (acc_exc && $stable(vld_q)));

  p_exc_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_exc |-> acc_done);
endmodule

// File: tb/tb_icache_tag_port.sv
module tb_icache_tag_port;
  logic clk = 1'b0, rst_n = 1'b0, xlat_en = 1'b0;
  logic acc_start = 1'b0, acc_we = 1'b0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic acc_ready, acc_done, acc_exc, xl_req_valid;
  logic [31:0] acc_rdata;
  logic [21:0] xl_req_vtag;
  logic xl_req_ready = 1'b0, xl_rsp_valid = 1'b0, xl_rsp_hit = 1'b0, xl_rsp_multi = 1'b0;
  logic [21:0] xl_rsp_ptag = '0;

  int errors = 0, checks = 0;
  logic [21:0] tr_ptag = '0, seen_vtag = '0;
  logic tr_hit = 1'b0, tr_multi = 1'b0;
  int tr_delay = 2;

  icache_tag_port dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic op(input logic we, input logic [31:0] a, input logic [31:0] d,
                    output logic done, output logic [31:0] rd);
    @(negedge clk);
    acc_start = 1'b1; acc_we = we; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_start = 1'b0;
    done = acc_done; rd = acc_rdata;
  endtask

  task automatic xop(input logic [31:0] a, input logic [31:0] d,
                     output logic done, output logic exc, output logic stall_ok);
    @(negedge clk);
    acc_start = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_start = 1'b0;
    done = 1'b0; exc = 1'b0; stall_ok = 1'b1;
    for (int k = 0; k < 30; k++) begin
      if (acc_done) begin done = 1'b1; exc = acc_exc; break; end
      if (acc_ready) stall_ok = 1'b0;
      @(negedge clk);
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (xl_req_valid) begin
      seen_vtag = xl_req_vtag;
      xl_req_ready = 1'b1;
      @(negedge clk);
      xl_req_ready = 1'b0;
      repeat (tr_delay) @(negedge clk);
      xl_rsp_valid = 1'b1; xl_rsp_ptag = tr_ptag; xl_rsp_hit = tr_hit; xl_rsp_multi = tr_multi;
      @(negedge clk);
      xl_rsp_valid = 1'b0;
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog timeout");
    report();
  end

  // {we, addr, wdata, expected read data}
  localparam logic [96:0] VEC [12] = '{
    {1'b1, 32'hF000_0060, 32'h048D_17FF, 32'h0},           // R3 R11 write idx3, junk reserved bits
    {1'b0, 32'hF000_0060, 32'h0,         32'h048D_1401},   // R3 R11
    {1'b0, 32'hF000_0068, 32'h0,         32'h048D_1401},   // R2 flag set on read
    {1'b1, 32'hF000_1FE0, 32'hFFFF_FC01, 32'h0},           // R3 idx255 full tag
    {1'b0, 32'hF000_1FE0, 32'h0,         32'hFFFF_FC01},
    {1'b1, 32'hF000_0068, 32'h048D_17FE, 32'h0},           // R4 assoc invalidate
    {1'b0, 32'hF000_0060, 32'h0,         32'h048D_1400},   // R4
    {1'b1, 32'hF000_0068, 32'h048D_1401, 32'h0},           // R5 entry invalid
    {1'b0, 32'hF000_0060, 32'h0,         32'h048D_1400},   // R5
    {1'b1, 32'hF000_1FE8, 32'hFFFF_F800, 32'h0},           // R5 tag mismatch
    {1'b0, 32'hF000_1FE0, 32'h0,         32'hFFFF_FC01},   // R5
    {1'b0, 32'hF000_0000, 32'h0,         32'h0}            // R9 untouched entry
  };

  initial begin
    logic d, e, s;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    chk(acc_ready && !acc_done && !xl_req_valid, "R9 reset outputs", {29'd0, acc_ready, acc_done, xl_req_valid}, 32'h4);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      op(VEC[i][96], VEC[i][95:64], VEC[i][63:32], d, rd);
      chk(d, "R10 done after access", {31'd0, d}, 32'd1);
      if (!VEC[i][96]) chk(rd == VEC[i][31:0], "R2 R3 R4 R5 R11 read data", rd, VEC[i][31:0]);
    end

    // R1 outside window
    @(negedge clk);
    acc_start = 1'b1; acc_we = 1'b1; acc_addr = 32'hF100_0060; acc_wdata = 32'h0;
    @(negedge clk);
    acc_start = 1'b0;
    s = 1'b1;
    for (int k = 0; k < 4; k++) begin
      if (acc_done || !acc_ready) s = 1'b0;
      @(negedge clk);
    end
    chk(s, "R1 no done, ready kept", {31'd0, s}, 32'd1);
    op(1'b0, 32'hF000_0060, 32'h0, d, rd);
    chk(rd == 32'h048D_1400, "R1 entry unchanged", rd, 32'h048D_1400);

    // R10 done is a single pulse
    @(negedge clk);
    chk(!acc_done, "R10 done one cycle", {31'd0, acc_done}, 32'd0);

    // translated path, idx5 tag 0xABC
    xlat_en = 1'b1;
    op(1'b1, 32'hF000_00A0, 32'h002A_F001, d, rd);
    tr_ptag = 22'h00ABC; tr_hit = 1'b1; tr_multi = 1'b0;
    xop(32'hF000_00A8, 32'h0444_4400, d, e, s);
    chk(d && !e, "R6 translated hit done, no exc", {30'd0, d, e}, 32'd2);
    chk(s, "R6 stalled until response", {31'd0, s}, 32'd1);
    chk(seen_vtag == 22'h11111, "R6 vtag sent", {10'd0, seen_vtag}, 32'h11111);
    op(1'b0, 32'hF000_00A0, 32'h0, d, rd);
    chk(rd == 32'h002A_F000, "R6 invalidated via physical tag", rd, 32'h002A_F000);

    op(1'b1, 32'hF000_00A0, 32'h002A_F001, d, rd);
    tr_hit = 1'b0;
    xop(32'hF000_00A8, 32'h0444_4400, d, e, s);
    chk(d && !e, "R7 miss done, no exc", {30'd0, d, e}, 32'd2);
    op(1'b0, 32'hF000_00A0, 32'h0, d, rd);
    chk(rd == 32'h002A_F001, "R7 miss no-op", rd, 32'h002A_F001);

    tr_hit = 1'b1; tr_ptag = 22'h00ABD;
    xop(32'hF000_00A8, 32'h0444_4400, d, e, s);
    op(1'b0, 32'hF000_00A0, 32'h0, d, rd);
    chk(rd == 32'h002A_F001 && !e, "R5 translated mismatch no-op", rd, 32'h002A_F001);

    tr_ptag = 22'h00ABC; tr_multi = 1'b1;
    xop(32'hF000_00A8, 32'h0444_4400, d, e, s);
    chk(d && e, "R8 multi exc with done", {30'd0, d, e}, 32'd3);
    @(negedge clk);
    chk(!acc_exc, "R8 exc single pulse", {31'd0, acc_exc}, 32'd0);
    op(1'b0, 32'hF000_00A0, 32'h0, d, rd);
    chk(rd == 32'h002A_F001, "R8 entry unchanged", rd, 32'h002A_F001);

    // R9 reset clears entries
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    op(1'b0, 32'hF000_1FE0, 32'h0, d, rd);
    chk(rd == 32'h0, "R9 entry cleared by reset", rd, 32'h0);
    op(1'b0, 32'hF000_00A0, 32'h0, d, rd);
    chk(rd == 32'h0, "R9 entry cleared by reset", rd, 32'h0);

    report();
  end
endmodule